// File: doc/BRIEF.md
# RTC interrupt and register file

This block is the bus-facing register file of a real-time clock. A simple request/write-enable bus carrying 32-bit words reaches configuration registers: control, a scratch word, a time-load value, a calibration-load value and an alarm value. The block drives these straight out to the time-keeping logic that sits beside it. The same bus reaches read-only views of live values that the time-keeping logic supplies: the current seconds count, the tick count, the calibration in force and the time-load value as captured.

Two interrupt groups live here. The clock-event group has two sources: a tick pulse on bit 0 and an alarm-match pulse on bit 1. The bus-error group has one source, an access to an unmapped or misaligned address. Each group has a status register that is cleared by writing ones, and a mask register that software can only read. Each group also has an unmask strobe register that clears mask bits and a mask-set strobe register that sets them. Each group drives one level-sensitive interrupt line. A line is high while any status bit is set whose mask bit is clear.

Byte offsets: 0x00 control, 0x04 scratch, 0x08 time-load, 0x0C time-load readback, 0x10 calibration-load, 0x14 calibration readback, 0x18 current time, 0x1C tick count, 0x20 alarm, 0x24 event status, 0x28 event mask, 0x2C event unmask, 0x30 event mask-set, 0x34 error status, 0x38 error mask, 0x3C error unmask, 0x40 error mask-set. Every offset from 0x44 up is unmapped.

Top module: `rtc_regfile`

## Requirements
- R1: After reset the event mask reads 0x3, the error mask reads 0x1, both status registers read 0, both interrupt lines are low, control reads 0x01000000 and the scratch, time-load, calibration-load and alarm registers read 0.
- R2: Each interrupt line is high exactly when its group has a status bit at 1 whose mask bit is 0; the two groups are independent.
- R3: A pulse on event input bit 0 (tick) or bit 1 (alarm) sets the same bit of event status; any bus access to an unmapped offset or to an address with bits [1:0] not zero sets error status bit 0.
- R4: Writing 1 to a status bit clears it and writing 0 leaves it; when a set and a clear of one bit fall in the same cycle, the bit ends up set.
- R5: Writes to the mask offsets (0x28, 0x38) change nothing.
- R6: Writing 1s to an unmask offset (0x2C, 0x3C) clears those mask bits; writing 1s to a mask-set offset (0x30, 0x40) sets them; these four offsets always read 0.
- R7: Offsets 0x0C, 0x18 read their live inputs in full, 0x14 reads only the low 21 bits of its input, 0x1C reads only the low 16 bits; writes to these four offsets are ignored.
- R8: Control bits in 0x70FFFFFE always read 0 and ignore writes; the other bits (mask 0x8F000001) store the written value and drive the control output.
- R9: Scratch, time-load, calibration-load and alarm store all 32 written bits; the last three drive their outputs.
- R10: A read of an unmapped or misaligned address returns 0, and a misaligned write changes no register.
- R11: Read data appears on the cycle after the read request and shows the state from before that clock edge; a write that changes status or mask changes the interrupt line at the same edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_req_i | input | 1 | Access request for this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | AW (7) | Byte address |
| bus_wdata_i | input | 32 | Write data, little-endian word |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read request |
| evt_i | input | EVT_N (2) | Event pulses: bit 0 tick, bit 1 alarm match |
| time_now_i | input | 32 | Current seconds count from the time-keeping logic |
| time_load_rb_i | input | 32 | Time-load value as captured by the time-keeping logic |
| cal_rb_i | input | 32 | Calibration in force (low CAL_RB_W bits significant) |
| tick_now_i | input | 32 | Sub-second tick count (low TICK_W bits significant) |
| ctrl_o | output | 32 | Control register value |
| time_load_o | output | 32 | Time-load register value |
| cal_load_o | output | 32 | Calibration-load register value |
| alarm_o | output | 32 | Alarm register value |
| evt_irq_o | output | 1 | Clock-event interrupt line |
| err_irq_o | output | 1 | Bus-error interrupt line |

## Verification
The bench builds the block with its default parameters. A 7-bit byte address leaves fifteen unmapped word offsets above the map, so the error path can be reached both by out-of-range and by misaligned accesses. Readback widths of 21 and 16 bits are checked by driving all-ones on the 32-bit live inputs. With two event sources, the bench can set one bit while a clear hits the other bit, or hits the same bit, and can tell the two cases apart.

// File: rtl/rtc_regs_pkg.sv
package rtc_regs_pkg;

  localparam int DW   = 32;
  localparam int IXW  = 5;
  localparam int NREG = 17;

  // Word index of each register (byte offset = index * 4)
  localparam logic [IXW-1:0] IX_CTRL    = 5'd0;
  localparam logic [IXW-1:0] IX_SCR     = 5'd1;
  localparam logic [IXW-1:0] IX_LOAD    = 5'd2;
  localparam logic [IXW-1:0] IX_LOAD_RB = 5'd3;
  localparam logic [IXW-1:0] IX_CAL     = 5'd4;
  localparam logic [IXW-1:0] IX_CAL_RB  = 5'd5;
  localparam logic [IXW-1:0] IX_NOW     = 5'd6;
  localparam logic [IXW-1:0] IX_TICK    = 5'd7;
  localparam logic [IXW-1:0] IX_ALARM   = 5'd8;
  localparam logic [IXW-1:0] IX_EST     = 5'd9;
  localparam logic [IXW-1:0] IX_EMSK    = 5'd10;
  localparam logic [IXW-1:0] IX_EUNM    = 5'd11;
  localparam logic [IXW-1:0] IX_EMSET   = 5'd12;
  localparam logic [IXW-1:0] IX_XST     = 5'd13;
  localparam logic [IXW-1:0] IX_XMSK    = 5'd14;
  localparam logic [IXW-1:0] IX_XUNM    = 5'd15;
  localparam logic [IXW-1:0] IX_XMSET   = 5'd16;

  // Plain read/write words built by one generate loop
  localparam int NPLAIN = 4;
  localparam logic [IXW-1:0] PLAIN_IX [NPLAIN] = '{IX_SCR, IX_LOAD, IX_CAL, IX_ALARM};

endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/rtc_addr_dec.sv
module rtc_addr_dec
  import rtc_regs_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic           req_i,
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  output logic [IXW-1:0] ix_o,
  output logic           wr_o,
  output logic           rd_o,
  output logic           bad_o
);

  localparam int WAW = AW - 2;

  logic [WAW-1:0] word;

  assign word = addr_i[AW-1:2];

  always_comb begin
    bad_o = (addr_i[1:0] != 2'b00) || (word >= WAW'(NREG));
    ix_o  = IXW'(word);
    wr_o  = req_i &  we_i & ~bad_o;
    rd_o  = req_i & ~we_i;
  end

endmodule

// File: rtl/rtc_cfg_reg.sv
module rtc_cfg_reg #(
  parameter int         W     = 32,
  parameter logic [W-1:0] RST   = '0,
  parameter logic [W-1:0] WMASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q;
  logic [W-1:0] d;

  always_comb d = wdata_i & WMASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= RST;
    else if (we_i) q <= d;
  end

  assign q_o = q;

endmodule

// File: rtl/rtc_irq_grp.sv
module rtc_irq_grp #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic         unm_we_i,
  input  logic         msk_we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] stat_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);

  logic [N-1:0] stat_q, stat_d;
  logic [N-1:0] mask_q, mask_d;
  logic [N-1:0] clr_bits;

  // Clear first, then set: a same-cycle set survives (R4)
  always_comb begin
    clr_bits = clr_we_i ? wdata_i : '0;
    stat_d   = (stat_q & ~clr_bits) | set_i;
  end

  // Mask changes only through the two strobe registers (R5, R6)
  always_comb begin
    mask_d = mask_q;
    if (unm_we_i)      mask_d = mask_q & ~wdata_i;
    else if (msk_we_i) mask_d = mask_q |  wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = |(stat_q & ~mask_q);

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_regs_pkg::*;
#(
  parameter int          AW         = 7,
  parameter int          EVT_N      = 2,
  parameter int          CAL_RB_W   = 21,
  parameter int          TICK_W     = 16,
  parameter logic [31:0] CTRL_RST   = 32'h0100_0000,
  parameter logic [31:0] CTRL_WMASK = 32'h8F00_0001
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_req_i,
  input  logic             bus_we_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [31:0]      bus_wdata_i,
  output logic [31:0]      bus_rdata_o,
  input  logic [EVT_N-1:0] evt_i,
  input  logic [31:0]      time_now_i,
  input  logic [31:0]      time_load_rb_i,
  input  logic [31:0]      cal_rb_i,
  input  logic [31:0]      tick_now_i,
  output logic [31:0]      ctrl_o,
  output logic [31:0]      time_load_o,
  output logic [31:0]      cal_load_o,
  output logic [31:0]      alarm_o,
  output logic             evt_irq_o,
  output logic             err_irq_o
);

  localparam logic [31:0] CAL_MASK  = 32'((64'd1 << CAL_RB_W) - 64'd1);
  localparam logic [31:0] TICK_MASK = 32'((64'd1 << TICK_W) - 64'd1);

  logic             rst_n;
  logic [IXW-1:0]   ix;
  logic             wr_en, rd_en, bad;
  logic [31:0]      ctrl_q;
  logic [31:0]      plain_q [NPLAIN];
  logic             ctrl_we;
  logic             evt_clr_we, evt_unm_we, evt_msk_we;
  logic             err_clr_we, err_unm_we, err_msk_we;
  logic [EVT_N-1:0] evt_stat, evt_mask;
  logic [0:0]       err_stat, err_mask;
  logic [0:0]       err_set;
  logic [31:0]      rd_val, rdata_d, rdata_q;

  rtc_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  rtc_addr_dec #(.AW(AW)) u_dec (
    .req_i  (bus_req_i),
    .we_i   (bus_we_i),
    .addr_i (bus_addr_i),
    .ix_o   (ix),
    .wr_o   (wr_en),
    .rd_o   (rd_en),
    .bad_o  (bad)
  );

  // Write strobes
  always_comb begin
    ctrl_we    = wr_en && (ix == IX_CTRL);
    evt_clr_we = wr_en && (ix == IX_EST);
    evt_unm_we = wr_en && (ix == IX_EUNM);
    evt_msk_we = wr_en && (ix == IX_EMSET);
    err_clr_we = wr_en && (ix == IX_XST);
    err_unm_we = wr_en && (ix == IX_XUNM);
    err_msk_we = wr_en && (ix == IX_XMSET);
    err_set    = bus_req_i & bad;   // R3: unmapped or misaligned access
  end

  // Control: reserved bits forced to zero (R8)
  rtc_cfg_reg #(.W(32), .RST(CTRL_RST), .WMASK(CTRL_WMASK)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .we_i    (ctrl_we),
    .wdata_i (bus_wdata_i),
    .q_o     (ctrl_q)
  );

  // Plain 32-bit words (R9)
  for (genvar g = 0; g < NPLAIN; g++) begin : g_plain
    logic plain_we;
    assign plain_we = wr_en && (ix == PLAIN_IX[g]);
    rtc_cfg_reg #(.W(32), .RST('0), .WMASK('1)) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_n),
      .we_i    (plain_we),
      .wdata_i (bus_wdata_i),
      .q_o     (plain_q[g])
    );
  end

  rtc_irq_grp #(.N(EVT_N)) u_evt (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .set_i    (evt_i),
    .clr_we_i (evt_clr_we),
    .unm_we_i (evt_unm_we),
    .msk_we_i (evt_msk_we),
    .wdata_i  (bus_wdata_i[EVT_N-1:0]),
    .stat_o   (evt_stat),
    .mask_o   (evt_mask),
    .irq_o    (evt_irq_o)
  );

  rtc_irq_grp #(.N(1)) u_err (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .set_i    (err_set),
    .clr_we_i (err_clr_we),
    .unm_we_i (err_unm_we),
    .msk_we_i (err_msk_we),
    .wdata_i  (bus_wdata_i[0:0]),
    .stat_o   (err_stat),
    .mask_o   (err_mask),
    .irq_o    (err_irq_o)
  );

  // Read mux: strobe registers and unmapped offsets read zero (R6, R10)
  always_comb begin
    case (ix)
      IX_CTRL:    rd_val = ctrl_q;
      IX_SCR:     rd_val = plain_q[0];
      IX_LOAD:    rd_val = plain_q[1];
      IX_LOAD_RB: rd_val = time_load_rb_i;
      IX_CAL:     rd_val = plain_q[2];
      IX_CAL_RB:  rd_val = cal_rb_i & CAL_MASK;
      IX_NOW:     rd_val = time_now_i;
      IX_TICK:    rd_val = tick_now_i & TICK_MASK;
      IX_ALARM:   rd_val = plain_q[3];
      IX_EST:     rd_val = 32'(evt_stat);
      IX_EMSK:    rd_val = 32'(evt_mask);
      IX_XST:     rd_val = 32'(err_stat);
      IX_XMSK:    rd_val = 32'(err_mask);
      default:    rd_val = '0;
    endcase
    rdata_d = bad ? '0 : rd_val;
  end

  // Registered read data, one cycle after the request (R11)
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign bus_rdata_o = rdata_q;
  assign ctrl_o      = ctrl_q;
  assign time_load_o = plain_q[1];
  assign cal_load_o  = plain_q[2];
  assign alarm_o     = plain_q[3];

endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk
  import rtc_regs_pkg::*;
#(
  parameter int AW    = 7,
  parameter int EVT_N = 2
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             bus_req_i,
  input logic             bus_we_i,
  input logic [AW-1:0]    bus_addr_i,
  input logic [31:0]      bus_rdata_o,
  input logic [EVT_N-1:0] evt_i,
  input logic [EVT_N-1:0] evt_stat,
  input logic [EVT_N-1:0] evt_mask,
  input logic [0:0]       err_stat,
  input logic [0:0]       err_mask,
  input logic             evt_unm_we,
  input logic             evt_msk_we,
  input logic             err_unm_we,
  input logic             err_msk_we,
  input logic [31:0]      ctrl_o,
  input logic             evt_irq_o,
  input logic             err_irq_o
);

  logic bad_acc;
  assign bad_acc = (bus_addr_i[1:0] != 2'b00) || (bus_addr_i[AW-1:2] >= (AW-2)'(NREG));

  p_quiet_after_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(rst_n) |-> (evt_mask == {EVT_N{1'b1}}) && err_mask[0] && !evt_irq_o && !err_irq_o);

  p_unmasked_event_irq_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((|(evt_i & ~evt_mask)) && !evt_msk_we) |=> evt_irq_o);

  p_bad_access_sets_err_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_req_i && bad_acc) |=> err_stat[0]);

  p_set_beats_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    evt_i[0] |=> evt_stat[0]);

  p_evt_mask_held_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!evt_unm_we && !evt_msk_we) |=> $stable(evt_mask));

  p_err_mask_held_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!err_unm_we && !err_msk_we) |=> $stable(err_mask));

  p_maskset_only_adds_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    evt_msk_we |=> ((evt_mask & $past(evt_mask)) == $past(evt_mask)));

  p_unmask_only_removes_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    evt_unm_we |=> ((evt_mask | $past(evt_mask)) == $past(evt_mask)));

  p_ctrl_reserved_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ctrl_o & 32'h70FF_FFFE) == 32'h0);

  p_bad_read_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_req_i && !bus_we_i && bad_acc) |=> (bus_rdata_o == 32'h0));

endmodule

bind rtc_regfile rtc_regfile_chk #(.AW(AW), .EVT_N(EVT_N)) u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_n),
  .bus_req_i   (bus_req_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o),
  .evt_i       (evt_i),
  .evt_stat    (evt_stat),
  .evt_mask    (evt_mask),
  .err_stat    (err_stat),
  .err_mask    (err_mask),
  .evt_unm_we  (evt_unm_we),
  .evt_msk_we  (evt_msk_we),
  .err_unm_we  (err_unm_we),
  .err_msk_we  (err_msk_we),
  .ctrl_o      (ctrl_o),
  .evt_irq_o   (evt_irq_o),
  .err_irq_o   (err_irq_o)
);

// File: tb/rtc_regfile_tb_top.sv
module rtc_regfile_tb_top;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  evt = '0;
  logic [31:0] t_now = '0, t_lrb = '0, t_cal = '0, t_tick = '0;
  logic [31:0] ctrl, tload, cload, alarm;
  logic        evt_irq, err_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit cmp_en = 1'b0;

  always #5 clk = ~clk;

  rtc_regfile dut_i (
    .clk_i (clk), .rst_ni (rst_ni),
    .bus_req_i (req), .bus_we_i (we), .bus_addr_i (addr),
    .bus_wdata_i (wdata), .bus_rdata_o (rdata),
    .evt_i (evt),
    .time_now_i (t_now), .time_load_rb_i (t_lrb), .cal_rb_i (t_cal), .tick_now_i (t_tick),
    .ctrl_o (ctrl), .time_load_o (tload), .cal_load_o (cload), .alarm_o (alarm),
    .evt_irq_o (evt_irq), .err_irq_o (err_irq)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_ctrl, m_scr, m_load, m_cal, m_alarm, m_rd;
  logic [1:0]  m_es, m_em;
  logic        m_xs, m_xm, m_rd_pend;
  string       m_rd_tag;

  function automatic bit is_bad(input logic [6:0] a);
    return (a[1:0] != 2'b00) || (a[6:2] > 5'd16);
  endfunction

  function automatic logic [31:0] model_read(input logic [6:0] a);
    if (is_bad(a)) return 32'h0;
    case (a[6:2])
      5'd0:  return m_ctrl;
      5'd1:  return m_scr;
      5'd2:  return m_load;
      5'd3:  return t_lrb;
      5'd4:  return m_cal;
      5'd5:  return t_cal & 32'h001F_FFFF;
      5'd6:  return t_now;
      5'd7:  return t_tick & 32'h0000_FFFF;
      5'd8:  return m_alarm;
      5'd9:  return {30'h0, m_es};
      5'd10: return {30'h0, m_em};
      5'd13: return {31'h0, m_xs};
      5'd14: return {31'h0, m_xm};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [6:0] a);
    if (is_bad(a)) return "R10";
    case (a[6:2])
      5'd0: return "R8";
      5'd3, 5'd5, 5'd6, 5'd7: return "R7";
      5'd9, 5'd13: return "R4";
      5'd10, 5'd14: return "R5";
      5'd11, 5'd12, 5'd15, 5'd16: return "R6";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ctrl = 32'h0100_0000; m_scr = '0; m_load = '0; m_cal = '0; m_alarm = '0;
      m_es = '0; m_em = 2'b11; m_xs = 1'b0; m_xm = 1'b1;
      m_rd = '0; m_rd_pend = 1'b0; m_rd_tag = "R11";
    end else begin
      m_rd_pend = 1'b0;
      if (req && !we) begin
        m_rd = model_read(addr); m_rd_pend = 1'b1; m_rd_tag = tag_of(addr);
      end
      if (req && we && !is_bad(addr)) begin
        case (addr[6:2])
          5'd0:  m_ctrl  = wdata & 32'h8F00_0001;
          5'd1:  m_scr   = wdata;
          5'd2:  m_load  = wdata;
          5'd4:  m_cal   = wdata;
          5'd8:  m_alarm = wdata;
          5'd9:  m_es    = m_es & ~wdata[1:0];
          5'd11: m_em    = m_em & ~wdata[1:0];
          5'd12: m_em    = m_em |  wdata[1:0];
          5'd13: m_xs    = m_xs & ~wdata[0];
          5'd15: m_xm    = m_xm & ~wdata[0];
          5'd16: m_xm    = m_xm |  wdata[0];
          default: ;
        endcase
      end
      m_es = m_es | evt;
      if (req && is_bad(addr)) m_xs = 1'b1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R2", {31'h0, evt_irq}, {31'h0, |(m_es & ~m_em)});
      chk("R2", {31'h0, err_irq}, {31'h0, m_xs & ~m_xm});
      chk("R8", ctrl, m_ctrl);
      chk("R9", tload, m_load);
      chk("R9", cload, m_cal);
      chk("R9", alarm, m_alarm);
      if (m_rd_pend) chk(m_rd_tag, rdata, m_rd);
    end
  end

  // ---------------- bus tasks ----------------
  task automatic bus_wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0; d = rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [6:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic pulse(input logic [1:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = 2'b00;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    cmp_en = 1'b1;

    // R1 reset state
    chk("R1", {31'h0, evt_irq}, 32'h0);
    chk("R1", {31'h0, err_irq}, 32'h0);
    chk("R1", ctrl, 32'h0100_0000);
    rd_chk("R1", 7'h28, 32'h3);
    rd_chk("R1", 7'h38, 32'h1);
    rd_chk("R1", 7'h24, 32'h0);
    rd_chk("R1", 7'h04, 32'h0);

    // R9 plain words
    bus_wr(7'h04, 32'hA5A5_5A5A); rd_chk("R9", 7'h04, 32'hA5A5_5A5A);
    bus_wr(7'h20, 32'h1234_5678); chk("R9", alarm, 32'h1234_5678);
    bus_wr(7'h08, 32'hCAFE_F00D); chk("R9", tload, 32'hCAFE_F00D);
    bus_wr(7'h10, 32'h0BAD_BEEF); chk("R9", cload, 32'h0BAD_BEEF);

    // R8 control reserved bits
    bus_wr(7'h00, 32'hFFFF_FFFF); rd_chk("R8", 7'h00, 32'h8F00_0001);
    bus_wr(7'h00, 32'h0); rd_chk("R8", 7'h00, 32'h0);

    // R7 read-only live views
    t_now = 32'h1122_3344; t_lrb = 32'h5566_7788; t_cal = '1; t_tick = '1;
    bus_wr(7'h18, 32'h0);
    rd_chk("R7", 7'h18, 32'h1122_3344);
    rd_chk("R7", 7'h14, 32'h001F_FFFF);
    rd_chk("R7", 7'h1C, 32'h0000_FFFF);
    rd_chk("R7", 7'h0C, 32'h5566_7788);

    // Event group
    pulse(2'b01);
    rd_chk("R3", 7'h24, 32'h1);
    chk("R2", {31'h0, evt_irq}, 32'h0);
    bus_wr(7'h2C, 32'h1);
    chk("R11", {31'h0, evt_irq}, 32'h1);
    rd_chk("R6", 7'h28, 32'h2);
    rd_chk("R6", 7'h2C, 32'h0);
    bus_wr(7'h28, 32'h3); rd_chk("R5", 7'h28, 32'h2);
    bus_wr(7'h24, 32'h2); rd_chk("R4", 7'h24, 32'h1);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = 7'h24; wdata = 32'h1; evt = 2'b01;
    @(negedge clk); req = 1'b0; we = 1'b0; evt = 2'b00;
    rd_chk("R4", 7'h24, 32'h1);
    bus_wr(7'h24, 32'h1);
    chk("R4", {31'h0, evt_irq}, 32'h0);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = 7'h24; evt = 2'b10;
    @(negedge clk); req = 1'b0; evt = 2'b00;
    chk("R11", rdata, 32'h0);
    chk("R2", {31'h0, evt_irq}, 32'h0);
    rd_chk("R3", 7'h24, 32'h2);
    bus_wr(7'h30, 32'h1); rd_chk("R6", 7'h28, 32'h3);
    bus_wr(7'h2C, 32'h2); chk("R2", {31'h0, evt_irq}, 32'h1);
    bus_wr(7'h30, 32'h2); chk("R2", {31'h0, evt_irq}, 32'h0);
    bus_wr(7'h24, 32'h3);

    // Error group
    rd_chk("R10", 7'h44, 32'h0);
    rd_chk("R3", 7'h34, 32'h1);
    chk("R2", {31'h0, err_irq}, 32'h0);
    bus_wr(7'h3C, 32'h1);
    chk("R6", {31'h0, err_irq}, 32'h1);
    bus_wr(7'h05, 32'h0);
    rd_chk("R10", 7'h04, 32'hA5A5_5A5A);
    rd_chk("R10", 7'h06, 32'h0);
    bus_wr(7'h34, 32'h1);
    chk("R4", {31'h0, err_irq}, 32'h0);
    bus_wr(7'h40, 32'h1);

    // Random traffic against the model
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      req   = ($urandom_range(0, 3) != 0);
      we    = $urandom_range(0, 1) == 1;
      addr  = ($urandom_range(0, 9) == 0) ? 7'($urandom_range(0, 127))
                                          : {5'($urandom_range(0, 18)), 2'b00};
      wdata = $urandom;
      evt   = ($urandom_range(0, 4) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      t_now = $urandom; t_lrb = $urandom; t_cal = $urandom; t_tick = $urandom;
    end
    @(negedge clk); req = 1'b0; evt = 2'b00;
    repeat (2) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule